// File: doc/BRIEF.md
# CAN Receive FIFO Object Allocator

This block chooses which message object receives an incoming CAN frame that has already been accepted for a FIFO group. A FIFO group is a run of consecutive message objects with identical acceptance settings. The last object of the run carries an end-of-buffer flag. The block keeps the per-object new-data and message-lost flags for all objects. On each accepted frame it reports a store strobe, the index of the target object and whether an unread message was overwritten.

The identifier match is done upstream. It delivers a frame strobe, a hit flag and the index of the first object of the matching group. The group extends from that index up to and including the first object whose end-of-buffer flag is set. A filled object is locked until the CPU releases it by clearing its new-data flag. The end-of-buffer object is never locked: once every object before it is full, each further frame replaces its contents. A group of N objects therefore keeps the N-1 oldest unread frames plus the newest one. The CPU drains the group by reading and releasing objects in ascending order.

Top module: `can_rx_fifo_alloc`

## Requirements
- R1: After reset every new-data and message-lost flag is 0, and the store and lost strobes are low.
- R2: A frame with `frame_vld_i` and `grp_hit_i` both high is stored in the lowest-numbered object at or above `grp_base_i` whose new-data flag is 0. The search ends at the first object at or above `grp_base_i` whose `eob_cfg_i` bit is 1.
- R3: One clock after the accepting edge, `store_o` is high for one cycle, `store_idx_o` gives the target object, and that object's `newdat_o` bit is 1.
- R4: An object with new-data 1 and end-of-buffer 0 is never chosen as a store target.
- R5: When every object of the group before the end-of-buffer object is locked, the frame goes to the end-of-buffer object. If that object's new-data was already 1, `lost_o` pulses with the store and its `msglst_o` bit becomes 1.
- R6: A bit of `release_i` clears that object's new-data flag at the next edge. A release in the same cycle as a frame takes effect first, so the released object can receive that frame.
- R7: No object is written and `store_o` stays low when `frame_vld_i` or `grp_hit_i` is low.
- R8: When no object at or above `grp_base_i` has its end-of-buffer bit set, the frame is dropped: no store and no flag change.
- R9: A message-lost flag stays set until its `lost_clr_i` bit is pulsed. A new loss in the same cycle as its clear leaves the flag set.
- R10: A store changes no flag of any object other than the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_vld_i | input | 1 | Accepted-frame strobe |
| grp_hit_i | input | 1 | Frame identifier matches a FIFO group |
| grp_base_i | input | IDX_W | Index of the first object of the matched group |
| eob_cfg_i | input | NUM_OBJ | End-of-buffer flag per object |
| release_i | input | NUM_OBJ | CPU new-data clear strobes, one per object |
| lost_clr_i | input | NUM_OBJ | CPU message-lost clear strobes, one per object |
| store_o | output | 1 | Frame written this cycle |
| store_idx_o | output | IDX_W | Object that received the frame |
| lost_o | output | 1 | The store overwrote an unread message |
| newdat_o | output | NUM_OBJ | New-data flag per object |
| msglst_o | output | NUM_OBJ | Message-lost flag per object |

## Verification
Two pairs of events can fall in the same cycle: a CPU release with an incoming frame, and a message-lost clear with a new overwrite of the same end-of-buffer object. Both are provoked by driving the strobe and the frame on one clock edge. For the release, the result is judged by the frame landing in the freshly released object with no loss reported. For the clear, it is judged by the lost flag still reading 1 afterwards.

// File: rtl/can_rx_fifo_alloc_pkg.sv
package can_rx_fifo_alloc_pkg;

    // How the last accepted frame was placed
    typedef enum logic [1:0] {
        PLACE_NONE      = 2'd0,
        PLACE_FREE      = 2'd1,
        PLACE_OVERWRITE = 2'd2
    } place_kind_e;

endpackage

// File: rtl/can_rx_fifo_span.sv
// Marks the objects that belong to the group starting at base_i:
// base_i up to and including the first end-of-buffer object.
module can_rx_fifo_span #(
    parameter int NUM_OBJ = 8,
    localparam int IDX_W  = $clog2(NUM_OBJ)
) (
    input  logic [IDX_W-1:0]   base_i,
    input  logic [NUM_OBJ-1:0] eob_i,
    output logic [NUM_OBJ-1:0] in_grp_o,
    output logic               closed_o
);

    always_comb begin
        logic done;
        done     = 1'b0;
        in_grp_o = '0;
        for (int i = 0; i < NUM_OBJ; i++) begin
            if ((i >= int'(base_i)) && !done) begin
                in_grp_o[i] = 1'b1;
                if (eob_i[i]) begin
                    done = 1'b1;
                end
            end
        end
        closed_o = done;
    end

endmodule

// File: rtl/can_rx_fifo_pick.sv
// Lowest-index selection among objects that may take a frame.
module can_rx_fifo_pick #(
    parameter int NUM_OBJ = 8,
    localparam int IDX_W  = $clog2(NUM_OBJ)
) (
    input  logic [NUM_OBJ-1:0] in_grp_i,
    input  logic [NUM_OBJ-1:0] busy_i,
    input  logic [NUM_OBJ-1:0] eob_i,
    output logic               vld_o,
    output logic [IDX_W-1:0]   idx_o
);

    logic [NUM_OBJ-1:0] cand;

    // The end-of-buffer object never locks; others only when free
    generate
        for (genvar g = 0; g < NUM_OBJ; g++) begin : g_cand
            assign cand[g] = in_grp_i[g] & (~busy_i[g] | eob_i[g]);
        end
    endgenerate

    always_comb begin
        vld_o = 1'b0;
        idx_o = '0;
        for (int i = NUM_OBJ - 1; i >= 0; i--) begin
            if (cand[i]) begin
                vld_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

    // A chosen object belongs to the group and is not a locked non-EoB object
    always_comb begin
        if (vld_o) begin
            assert_pick_not_locked_R4: assert (in_grp_i[idx_o] && !(busy_i[idx_o] && !eob_i[idx_o]));
        end
    end

endmodule

// File: rtl/can_rx_fifo_alloc.sv
module can_rx_fifo_alloc
    import can_rx_fifo_alloc_pkg::*;
#(
    parameter int NUM_OBJ = 8,
    localparam int IDX_W  = $clog2(NUM_OBJ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_vld_i,
    input  logic               grp_hit_i,
    input  logic [IDX_W-1:0]   grp_base_i,
    input  logic [NUM_OBJ-1:0] eob_cfg_i,
    input  logic [NUM_OBJ-1:0] release_i,
    input  logic [NUM_OBJ-1:0] lost_clr_i,
    output logic               store_o,
    output logic [IDX_W-1:0]   store_idx_o,
    output logic               lost_o,
    output logic [NUM_OBJ-1:0] newdat_o,
    output logic [NUM_OBJ-1:0] msglst_o
);

    typedef struct packed {
        logic [NUM_OBJ-1:0] newdat;
        logic [NUM_OBJ-1:0] msglst;
        place_kind_e        kind;
        logic [IDX_W-1:0]   idx;
    } alloc_st_t;

    alloc_st_t st_d, st_q;

    logic [NUM_OBJ-1:0] in_grp;
    logic               grp_closed;
    logic [NUM_OBJ-1:0] busy;
    logic               pick_vld;
    logic [IDX_W-1:0]   pick_idx;
    logic               take;

    // CPU release is applied before the search
    assign busy = st_q.newdat & ~release_i;

    can_rx_fifo_span #(.NUM_OBJ(NUM_OBJ)) i_span (
        .base_i   (grp_base_i),
        .eob_i    (eob_cfg_i),
        .in_grp_o (in_grp),
        .closed_o (grp_closed)
    );

    can_rx_fifo_pick #(.NUM_OBJ(NUM_OBJ)) i_pick (
        .in_grp_i (in_grp),
        .busy_i   (busy),
        .eob_i    (eob_cfg_i),
        .vld_o    (pick_vld),
        .idx_o    (pick_idx)
    );

    assign take = frame_vld_i && grp_hit_i && grp_closed && pick_vld;

    always_comb begin
        st_d        = st_q;
        st_d.kind   = PLACE_NONE;
        st_d.newdat = busy;
        st_d.msglst = st_q.msglst & ~lost_clr_i;
        if (take) begin
            st_d.idx              = pick_idx;
            st_d.newdat[pick_idx] = 1'b1;
            if (busy[pick_idx]) begin
                st_d.kind             = PLACE_OVERWRITE;
                st_d.msglst[pick_idx] = 1'b1;
            end else begin
                st_d.kind = PLACE_FREE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{newdat: '0, msglst: '0, kind: PLACE_NONE, idx: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign store_o     = (st_q.kind != PLACE_NONE);
    assign lost_o      = (st_q.kind == PLACE_OVERWRITE);
    assign store_idx_o = st_q.idx;
    assign newdat_o    = st_q.newdat;
    assign msglst_o    = st_q.msglst;

    // A store needs an accepted, matching frame in the previous cycle
    assert_store_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        store_o |-> $past(frame_vld_i && grp_hit_i));

    // The stored object reads back as holding new data
    assert_store_sets_newdat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        store_o |-> newdat_o[store_idx_o]);

    // At most one object gains new data per cycle
    assert_single_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(newdat_o & ~$past(newdat_o)) <= 1);

    // A loss is always recorded in the lost flags of the target
    assert_loss_recorded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lost_o |-> (msglst_o[store_idx_o] && $past(eob_cfg_i[store_idx_o])));

    // Lost flags never drop without a CPU clear
    assert_msglst_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(msglst_o) & ~$past(lost_clr_i) & ~msglst_o) == '0);

    // Without a frame nothing gains new data
    assert_no_frame_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_vld_i) |-> ((newdat_o & ~$past(newdat_o)) == '0));

endmodule

// File: tb/test_can_rx_fifo_alloc.sv
module test_can_rx_fifo_alloc;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_OBJ    = 8;
    localparam int IDX_W      = $clog2(NUM_OBJ);
    localparam int WATCHDOG   = 5000;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               frame_vld_i;
    logic               grp_hit_i;
    logic [IDX_W-1:0]   grp_base_i;
    logic [NUM_OBJ-1:0] eob_cfg_i;
    logic [NUM_OBJ-1:0] release_i;
    logic [NUM_OBJ-1:0] lost_clr_i;
    logic               store_o;
    logic [IDX_W-1:0]   store_idx_o;
    logic               lost_o;
    logic [NUM_OBJ-1:0] newdat_o;
    logic [NUM_OBJ-1:0] msglst_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    can_rx_fifo_alloc #(.NUM_OBJ(NUM_OBJ)) i_can_rx_fifo_alloc (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_vld_i (frame_vld_i),
        .grp_hit_i   (grp_hit_i),
        .grp_base_i  (grp_base_i),
        .eob_cfg_i   (eob_cfg_i),
        .release_i   (release_i),
        .lost_clr_i  (lost_clr_i),
        .store_o     (store_o),
        .store_idx_o (store_idx_o),
        .lost_o      (lost_o),
        .newdat_o    (newdat_o),
        .msglst_o    (msglst_o)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs at a falling edge; results are sampled at the next falling edge
    task automatic cycle(bit fv, bit hit, int base, int rel, int lclr);
        frame_vld_i = fv;
        grp_hit_i   = hit;
        grp_base_i  = IDX_W'(base);
        release_i   = NUM_OBJ'(rel);
        lost_clr_i  = NUM_OBJ'(lclr);
        @(negedge clk);
        frame_vld_i = 1'b0;
        grp_hit_i   = 1'b0;
        release_i   = '0;
        lost_clr_i  = '0;
    endtask

    task automatic expect_store(string req, int idx, bit lost, int nd);
        check({req, " store"}, int'(store_o), 1);
        check({req, " index"}, int'(store_idx_o), idx);
        check({req, " lost"}, int'(lost_o), int'(lost));
        check({req, " newdat"}, int'(newdat_o), nd);
    endtask

    task automatic t_reset();
        check("R1 newdat", int'(newdat_o), 0);
        check("R1 msglst", int'(msglst_o), 0);
        check("R1 store", int'(store_o), 0);
        check("R1 lost", int'(lost_o), 0);
    endtask

    task automatic t_fill();
        cycle(1, 1, 0, 0, 0); expect_store("R2 R3 first", 0, 0, 'h01);
        cycle(1, 1, 0, 0, 0); expect_store("R4 second", 1, 0, 'h03);
        cycle(1, 1, 0, 0, 0); expect_store("R4 third", 2, 0, 'h07);
        cycle(1, 1, 0, 0, 0); expect_store("R5 eob free", 3, 0, 'h0F);
        check("R5 msglst untouched", int'(msglst_o), 0);
    endtask

    task automatic t_overwrite();
        cycle(1, 1, 0, 0, 0); expect_store("R5 overwrite", 3, 1, 'h0F);
        check("R5 msglst set", int'(msglst_o), 'h08);
        cycle(1, 1, 0, 0, 0); expect_store("R5 overwrite again", 3, 1, 'h0F);
    endtask

    task automatic t_same_cycle_release();
        cycle(1, 1, 0, 'h02, 0); expect_store("R6 release with frame", 1, 0, 'h0F);
        cycle(0, 0, 0, 'h04, 0);
        check("R6 plain release", int'(newdat_o), 'h0B);
        check("R7 idle store", int'(store_o), 0);
        cycle(1, 1, 0, 0, 0); expect_store("R6 refill", 2, 0, 'h0F);
    endtask

    task automatic t_ignored();
        cycle(1, 0, 0, 'h01, 0);
        check("R7 no hit store", int'(store_o), 0);
        check("R7 no hit newdat", int'(newdat_o), 'h0E);
        cycle(0, 1, 0, 0, 0);
        check("R7 no valid store", int'(store_o), 0);
        check("R7 no valid newdat", int'(newdat_o), 'h0E);
        cycle(1, 1, 0, 0, 0); expect_store("R2 refill low", 0, 0, 'h0F);
    endtask

    task automatic t_second_group();
        cycle(1, 1, 4, 0, 0); expect_store("R10 second group", 4, 0, 'h1F);
        check("R10 msglst unchanged", int'(msglst_o), 'h08);
        cycle(1, 1, 5, 0, 0); expect_store("R2 mid base", 5, 0, 'h3F);
    endtask

    task automatic t_drain();
        for (int i = 0; i < 4; i++) begin
            cycle(0, 0, 0, 1 << i, 0);
        end
        check("R6 drained", int'(newdat_o), 'h30);
        cycle(1, 1, 0, 0, 0); expect_store("R2 after drain", 0, 0, 'h31);
    endtask

    task automatic t_msglst();
        cycle(0, 0, 0, 0, 'h08);
        check("R9 clear", int'(msglst_o), 0);
        cycle(1, 1, 0, 0, 0); expect_store("R9 fill1", 1, 0, 'h33);
        cycle(1, 1, 0, 0, 0); expect_store("R9 fill2", 2, 0, 'h37);
        cycle(1, 1, 0, 0, 0); expect_store("R9 fill3", 3, 0, 'h3F);
        cycle(1, 1, 0, 0, 'h08); expect_store("R9 set beats clear", 3, 1, 'h3F);
        check("R9 flag kept", int'(msglst_o), 'h08);
        cycle(0, 0, 0, 0, 0);
        check("R9 sticky", int'(msglst_o), 'h08);
    endtask

    task automatic t_open_span();
        eob_cfg_i = 8'b0000_1000;
        cycle(1, 1, 4, 0, 0);
        check("R8 no store", int'(store_o), 0);
        check("R8 newdat unchanged", int'(newdat_o), 'h3F);
        eob_cfg_i = 8'b1000_1000;
    endtask

    initial begin
        for (int n = 0; n < WATCHDOG; n++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n       = 1'b0;
        frame_vld_i = 1'b0;
        grp_hit_i   = 1'b0;
        grp_base_i  = '0;
        eob_cfg_i   = 8'b1000_1000;
        release_i   = '0;
        lost_clr_i  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill();
        t_overwrite();
        t_same_cycle_release();
        t_ignored();
        t_second_group();
        t_drain();
        t_msglst();
        t_open_span();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule